// File: doc/BRIEF.md
# Comma-Coded Trigger Link Framer

This block moves one trigger payload per bunch crossing across an 8b10b serial link. Each crossing occupies a frame of eight 16-bit words. The transmit half sends a frame-start comma in word 0. It sends the payload in words 1 to 7. Any payload word equal to zero goes out as a pair of zero-commas, so the receiver sees comma characters often and can realign quickly after a disturbance. The block therefore carries 112 usable payload bits per crossing. Word 0 is reserved for framing.

The receive half takes the decoded word stream and its per-byte K flags. It classifies each word and locks onto the frame-start comma. It rebuilds the payload and presents it with a one-cycle valid strobe. It also reports lock status and a per-word coding error flag. The encoder, decoder, SERDES and clock recovery sit outside this block and connect at the parallel word interface.

Top module: `tlf_link_framer`

## Requirements
- R1: The transmitter repeats an eight-word frame. `tx_take_o` is high in the cycle in which `tx_payload_i` is sampled. In the next cycle the output word is the frame-start comma: every byte is 8'hBC and every K flag is 1.
- R2: Output word j (j = 1..7) of a frame appears j cycles after the frame-start word. It carries `tx_payload_i[(j-1)*16 +: 16]` from the sampled payload, so word 1 holds the least significant bits.
- R3: A payload word equal to zero is sent as the zero-comma: every byte is 8'h3C and the K flags are 2'b11. A non-zero word is sent unchanged with K flags 2'b00. The transmitter never drives mixed K flags.
- R4: While reset is held, the transmitter outputs the zero-comma, `tx_take_o` is low, and `rx_lock_o`, `rx_valid_o` and `rx_err_o` are low.
- R5: The receiver takes a word with K flags 2'b00 as data unchanged. It takes a word with K flags 2'b11 and both bytes 8'h3C as the value zero.
- R6: The receiver raises `rx_lock_o` after the frame-start comma has appeared in four consecutive frames at eight-word spacing. Lock rises two cycles after the word that carries the fourth comma enters.
- R7: Once locked, lock drops only after two frames in a row whose expected slot 0 lacks the frame-start comma. A single missing comma leaves lock held.
- R8: While not locked, `rx_valid_o` stays low. Any frame-start comma then restarts the word counter at that word. This includes a comma found at an unexpected position while lock is being acquired, which restarts the count of good frames at one.
- R9: `rx_valid_o` pulses for one cycle, two cycles after a frame's word 7 enters. It pulses only if lock is held and that frame's slot 0 carried the frame-start comma. `rx_payload_o` then holds words 1..7, with word 1 in the least significant bits.
- R10: `rx_err_o` is high one cycle after an input word that has exactly one K flag set, or both K flags set with a byte pattern other than two 8'hBC or two 8'h3C. Such a word counts as zero in the payload. A frame-start comma in a data slot also counts as zero, without an error.
- R11: When the transmit output feeds the receive input directly, each valid received payload equals a payload the transmitter sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_payload_i | input | 112 | Payload for the next frame, sampled while tx_take_o is high |
| tx_take_o | output | 1 | Payload sample strobe, once per frame |
| tx_data_o | output | 16 | Outgoing word, two bytes |
| tx_k_o | output | 2 | Outgoing per-byte control flags |
| rx_data_i | input | 16 | Incoming decoded word |
| rx_k_i | input | 2 | Incoming per-byte control flags |
| rx_payload_o | output | 112 | Rebuilt payload |
| rx_valid_o | output | 1 | One-cycle strobe for rx_payload_o |
| rx_lock_o | output | 1 | Frame lock held |
| rx_err_o | output | 1 | Coding error on the word one cycle earlier |

## Verification
The bench loops the transmitter into the receiver and injects several kinds of damage into the stream: deleted and inserted words, a single dropped frame-start comma, two dropped in a row, stray frame-start commas in data slots, words with one K flag set, and unknown comma codes. A receiver that counted good frames wrongly, or dropped lock on the first miss, would move the lock edge by whole frames. One that failed to realign while acquiring would never relock after a slip. One that kept emitting after a missed frame start would strobe valid on a shifted payload. The payloads contain many zero words, plus data words whose bit patterns match the comma codes. A transmitter that keyed on the byte value alone, or a receiver that ignored the K flags, would corrupt those words.

// File: rtl/tlf_pkg.sv
package tlf_pkg;

    // Byte codes used with the K flag set.
    localparam logic [7:0] K_FRAME = 8'hBC;   // K28.5, marks word 0 of a frame
    localparam logic [7:0] K_NULL  = 8'h3C;   // K28.1, stands for a zero byte pair

    typedef enum logic [1:0] {
        WC_DATA  = 2'd0,
        WC_NULL  = 2'd1,
        WC_FRAME = 2'd2,
        WC_BAD   = 2'd3
    } word_cls_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2
    } lock_st_e;

    typedef struct packed {
        logic      err;
        word_cls_e cls;
    } rx_tag_t;

    // Byte chosen by the transmitter for one byte lane.
    function automatic logic [7:0] tx_byte(input logic is_frame, input logic is_null,
                                           input logic [7:0] data_byte);
        if (is_frame)
            return K_FRAME;
        else if (is_null)
            return K_NULL;
        else
            return data_byte;
    endfunction

endpackage

// File: rtl/tlf_tx_framer.sv
module tlf_tx_framer
    import tlf_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_WORDS = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [(FRAME_WORDS-1)*WORD_W-1:0]    payload_i,
    output logic                                 take_o,
    output logic [WORD_W-1:0]                    data_o,
    output logic [WORD_W/8-1:0]                  k_o
);
    localparam int BYTES = WORD_W / 8;
    localparam int PAY_W = (FRAME_WORDS - 1) * WORD_W;
    localparam int POS_W = $clog2(FRAME_WORDS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_WORDS - 1);

    logic [POS_W-1:0]  slot_q;
    logic [PAY_W-1:0]  hold_q;
    logic [WORD_W-1:0] word_sel;
    logic              at_frame;
    logic              word_null;
    logic [WORD_W-1:0] data_nx;
    logic [BYTES-1:0]  k_nx;

    assign at_frame = (slot_q == '0);
    assign take_o   = at_frame && !rst;

    always_comb begin
        int idx;
        idx      = at_frame ? 0 : int'(slot_q) - 1;
        word_sel = hold_q[idx*WORD_W +: WORD_W];
    end

    assign word_null = (word_sel == '0);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign data_nx[b*8 +: 8] = tx_byte(at_frame, word_null, word_sel[b*8 +: 8]);
        assign k_nx[b]           = at_frame || word_null;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            hold_q <= '0;
            data_o <= {BYTES{K_NULL}};
            k_o    <= '1;
        end else begin
            slot_q <= (slot_q == POS_LAST) ? '0 : slot_q + 1'b1;
            if (at_frame)
                hold_q <= payload_i;
            data_o <= data_nx;
            k_o    <= k_nx;
        end
    end

endmodule

// File: rtl/tlf_rx_classify.sv
module tlf_rx_classify
    import tlf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_W-1:0]   data_i,
    input  logic [WORD_W/8-1:0] k_i,
    output rx_tag_t             tag_o,
    output logic [WORD_W-1:0]   data_o
);
    localparam int BYTES = WORD_W / 8;

    logic [BYTES-1:0] lane_frame;
    logic [BYTES-1:0] lane_null;
    rx_tag_t          tag_nx;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_frame[b] = k_i[b] && (data_i[b*8 +: 8] == K_FRAME);
        assign lane_null[b]  = k_i[b] && (data_i[b*8 +: 8] == K_NULL);
    end

    always_comb begin
        if (k_i == '0)
            tag_nx.cls = WC_DATA;
        else if (&lane_frame)
            tag_nx.cls = WC_FRAME;
        else if (&lane_null)
            tag_nx.cls = WC_NULL;
        else
            tag_nx.cls = WC_BAD;
        tag_nx.err = (tag_nx.cls == WC_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o  <= '{err: 1'b0, cls: WC_DATA};
            data_o <= '0;
        end else begin
            tag_o  <= tag_nx;
            data_o <= data_i;
        end
    end

endmodule

// File: rtl/tlf_rx_align.sv
module tlf_rx_align
    import tlf_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int FRAME_WORDS   = 8,
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  rx_tag_t                           tag_i,
    input  logic [WORD_W-1:0]                 data_i,
    output logic [(FRAME_WORDS-1)*WORD_W-1:0] payload_o,
    output logic                              valid_o,
    output logic                              lock_o
);
    localparam int PAY_W  = (FRAME_WORDS - 1) * WORD_W;
    localparam int POS_W  = $clog2(FRAME_WORDS);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W = $clog2(UNLOCK_FRAMES + 1);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_WORDS - 1);
    localparam logic [POS_W-1:0]  POS_ONE   = POS_W'(1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
    localparam logic [GOOD_W-1:0] GOOD_ONE  = GOOD_W'(1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(UNLOCK_FRAMES - 1);

    lock_st_e          st_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_inc;
    logic [GOOD_W-1:0] good_q;
    logic [MISS_W-1:0] miss_q;
    logic              frame_ok_q;
    logic [PAY_W-1:0]  asm_q;
    logic [PAY_W-1:0]  asm_nx;
    logic [WORD_W-1:0] word_val;
    logic              is_frame;
    logic              at_start;

    assign is_frame = (tag_i.cls == WC_FRAME);
    assign at_start = (pos_q == '0);
    assign pos_inc  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    assign word_val = (tag_i.cls == WC_DATA) ? data_i : '0;
    assign lock_o   = (st_q == ST_LOCK);

    always_comb begin
        int idx;
        idx    = at_start ? 0 : int'(pos_q) - 1;
        asm_nx = asm_q;
        asm_nx[idx*WORD_W +: WORD_W] = word_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HUNT;
            pos_q      <= '0;
            good_q     <= '0;
            miss_q     <= '0;
            frame_ok_q <= 1'b0;
            asm_q      <= '0;
            payload_o  <= '0;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (st_q)
                ST_HUNT: begin
                    if (is_frame) begin
                        st_q   <= ST_ACQ;
                        pos_q  <= POS_ONE;
                        good_q <= GOOD_ONE;
                    end
                end
                ST_ACQ: begin
                    if (is_frame) begin
                        pos_q <= POS_ONE;
                        if (at_start) begin
                            good_q <= good_q + 1'b1;
                            if (good_q == GOOD_LAST) begin
                                st_q       <= ST_LOCK;
                                miss_q     <= '0;
                                frame_ok_q <= 1'b1;
                            end
                        end else begin
                            good_q <= GOOD_ONE;
                        end
                    end else if (at_start) begin
                        st_q  <= ST_HUNT;
                        pos_q <= '0;
                    end else begin
                        pos_q <= pos_inc;
                    end
                end
                ST_LOCK: begin
                    pos_q <= pos_inc;
                    if (at_start) begin
                        if (is_frame) begin
                            miss_q     <= '0;
                            frame_ok_q <= 1'b1;
                        end else begin
                            frame_ok_q <= 1'b0;
                            if (miss_q == MISS_LAST) begin
                                st_q  <= ST_HUNT;
                                pos_q <= '0;
                            end else begin
                                miss_q <= miss_q + 1'b1;
                            end
                        end
                    end else begin
                        asm_q <= asm_nx;
                        if (pos_q == POS_LAST && frame_ok_q) begin
                            payload_o <= asm_nx;
                            valid_o   <= 1'b1;
                        end
                    end
                end
                default: begin
                    st_q  <= ST_HUNT;
                    pos_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tlf_link_framer.sv
module tlf_link_framer
    import tlf_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int FRAME_WORDS   = 8,
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [(FRAME_WORDS-1)*WORD_W-1:0] tx_payload_i,
    output logic                              tx_take_o,
    output logic [WORD_W-1:0]                 tx_data_o,
    output logic [WORD_W/8-1:0]               tx_k_o,
    input  logic [WORD_W-1:0]                 rx_data_i,
    input  logic [WORD_W/8-1:0]               rx_k_i,
    output logic [(FRAME_WORDS-1)*WORD_W-1:0] rx_payload_o,
    output logic                              rx_valid_o,
    output logic                              rx_lock_o,
    output logic                              rx_err_o
);
    rx_tag_t           cls_tag;
    logic [WORD_W-1:0] cls_data;

    tlf_tx_framer #(
        .WORD_W      (WORD_W),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .payload_i (tx_payload_i),
        .take_o    (tx_take_o),
        .data_o    (tx_data_o),
        .k_o       (tx_k_o)
    );

    tlf_rx_classify #(
        .WORD_W (WORD_W)
    ) u_cls (
        .clk    (clk),
        .rst    (rst),
        .data_i (rx_data_i),
        .k_i    (rx_k_i),
        .tag_o  (cls_tag),
        .data_o (cls_data)
    );

    assign rx_err_o = cls_tag.err;

    tlf_rx_align #(
        .WORD_W        (WORD_W),
        .FRAME_WORDS   (FRAME_WORDS),
        .LOCK_FRAMES   (LOCK_FRAMES),
        .UNLOCK_FRAMES (UNLOCK_FRAMES)
    ) u_aln (
        .clk       (clk),
        .rst       (rst),
        .tag_i     (cls_tag),
        .data_i    (cls_data),
        .payload_o (rx_payload_o),
        .valid_o   (rx_valid_o),
        .lock_o    (rx_lock_o)
    );

endmodule

// File: rtl/tlf_link_framer_chk.sv
module tlf_link_framer_chk
    import tlf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                tx_take_o,
    input logic [WORD_W-1:0]   tx_data_o,
    input logic [WORD_W/8-1:0] tx_k_o,
    input logic [WORD_W-1:0]   rx_data_i,
    input logic [WORD_W/8-1:0] rx_k_i,
    input logic                rx_valid_o,
    input logic                rx_lock_o,
    input logic                rx_err_o
);
    localparam int BYTES = WORD_W / 8;

    // R1: the sample strobe is followed by the frame-start comma
    p_take_then_frame_r1: assert property (@(posedge clk) disable iff (rst)
        tx_take_o |=> (tx_k_o == '1 && tx_data_o == {BYTES{K_FRAME}}));

    // R3: a word sent as data is never zero
    p_no_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_k_o == '0) |-> (tx_data_o != '0));

    // R3: K flags move as a whole word
    p_k_whole_word_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_k_o == '0) || (tx_k_o == '1));

    // R9: a payload strobe only comes while locked
    p_valid_locked_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> rx_lock_o);

    // R9: the strobe lasts one cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R6: lock rises two cycles after a frame-start comma entered
    p_lock_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_lock_o) |-> $past(rx_k_i == '1 && rx_data_i == {BYTES{K_FRAME}}, 2));

    // R10: a word with mixed K flags raises the error flag
    p_mixed_k_err_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rx_k_i != '0 && rx_k_i != '1)) |-> rx_err_o);

endmodule

bind tlf_link_framer tlf_link_framer_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_take_o  (tx_take_o),
    .tx_data_o  (tx_data_o),
    .tx_k_o     (tx_k_o),
    .rx_data_i  (rx_data_i),
    .rx_k_i     (rx_k_i),
    .rx_valid_o (rx_valid_o),
    .rx_lock_o  (rx_lock_o),
    .rx_err_o   (rx_err_o)
);

// File: tb/sim_tlf_link_framer.sv
`timescale 1ns/1ps
module sim_tlf_link_framer;
    localparam int WW = 16;
    localparam int FW = 8;
    localparam int PW = (FW - 1) * WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] tx_payload_i = '0;
    logic          tx_take_o;
    logic [WW-1:0] tx_data_o;
    logic [1:0]    tx_k_o;
    logic [WW-1:0] rx_data_i = 16'h3C3C;
    logic [1:0]    rx_k_i = 2'b11;
    logic [PW-1:0] rx_payload_o;
    logic          rx_valid_o, rx_lock_o, rx_err_o;

    always #2 clk = ~clk;

    tlf_link_framer u0 (
        .clk(clk), .rst(rst), .tx_payload_i(tx_payload_i), .tx_take_o(tx_take_o),
        .tx_data_o(tx_data_o), .tx_k_o(tx_k_o), .rx_data_i(rx_data_i), .rx_k_i(rx_k_i),
        .rx_payload_o(rx_payload_o), .rx_valid_o(rx_valid_o), .rx_lock_o(rx_lock_o),
        .rx_err_o(rx_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- transmit reference ----------------
    int            t_cnt;
    logic [PW-1:0] t_hold;
    logic [WW-1:0] e_td;
    logic [1:0]    e_tk;
    logic [WW-1:0] t_w;

    always @(posedge clk) begin
        if (rst) begin
            t_cnt = 0; t_hold = '0; e_td = 16'h3C3C; e_tk = 2'b11;
        end else begin
            if (t_cnt == 0) begin
                t_hold = tx_payload_i; e_td = 16'hBCBC; e_tk = 2'b11;
            end else begin
                t_w = t_hold[(t_cnt-1)*WW +: WW];
                if (t_w == 0) begin e_td = 16'h3C3C; e_tk = 2'b11; end
                else begin e_td = t_w; e_tk = 2'b00; end
            end
            t_cnt = (t_cnt + 1) % FW;
        end
    end

    // ---------------- receive reference ----------------
    int            m_st, m_pos, m_good, m_miss, c1;
    bit            m_fok, e1, ev;
    logic [WW-1:0] d1, m_w;
    logic [WW-1:0] m_asm [1:7];
    logic [PW-1:0] ep;

    function automatic int kind(input logic [1:0] k, input logic [WW-1:0] d);
        if (k == 2'b00) return 0;
        if (k == 2'b11 && d == 16'hBCBC) return 2;
        if (k == 2'b11 && d == 16'h3C3C) return 1;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pos = 0; m_good = 0; m_miss = 0; m_fok = 0;
            c1 = 0; d1 = '0; e1 = 0; ev = 0; ep = '0;
            for (int j = 1; j <= 7; j++) m_asm[j] = '0;
        end else begin
            ev = 0;
            m_w = (c1 == 0) ? d1 : '0;
            if (m_st == 0) begin
                if (c1 == 2) begin m_st = 1; m_pos = 1; m_good = 1; end
            end else if (m_st == 1) begin
                if (c1 == 2) begin
                    if (m_pos == 0) begin
                        m_good++;
                        if (m_good == 4) begin m_st = 2; m_fok = 1; m_miss = 0; end
                    end else m_good = 1;
                    m_pos = 1;
                end else if (m_pos == 0) m_st = 0;
                else m_pos = (m_pos + 1) % FW;
            end else begin
                if (m_pos == 0) begin
                    if (c1 == 2) begin m_miss = 0; m_fok = 1; end
                    else begin
                        m_fok = 0; m_miss++;
                        if (m_miss == 2) m_st = 0;
                    end
                end else begin
                    m_asm[m_pos] = m_w;
                    if (m_pos == 7 && m_fok) begin
                        ev = 1;
                        for (int j = 1; j <= 7; j++) ep[(j-1)*WW +: WW] = m_asm[j];
                    end
                end
                m_pos = (m_st == 0) ? 0 : (m_pos + 1) % FW;
            end
            c1 = kind(rx_k_i, rx_data_i); d1 = rx_data_i; e1 = (c1 == 3);
        end
    end

    // ---------------- stimulus ----------------
    logic [17:0]   q[$];
    logic [17:0]   last_w = {2'b11, 16'h3C3C};
    logic [17:0]   cur;
    logic [PW-1:0] hist [4];
    int            hp = 0;
    bit            rt_en = 0, special = 0;
    bit            del_req = 0, ins_req = 0, nosof_req = 0, err1_req = 0, err2_req = 0, stray_req = 0;

    function automatic logic [PW-1:0] gen_payload(input bit sp);
        logic [PW-1:0] p;
        for (int j = 0; j < 7; j++) begin
            int r;
            r = $urandom % 4;
            if (r < 2) p[j*WW +: WW] = '0;
            else if (sp && r == 2) p[j*WW +: WW] = (j % 2 == 1) ? 16'hBCBC : 16'h3C3C;
            else p[j*WW +: WW] = 16'($urandom) | 16'h0001;
        end
        return p;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            check((e_tk == 2'b11 && e_td == 16'hBCBC) ? "R1 frame word" :
                  (e_tk == 2'b11) ? "R3 zero comma" : "R2 data word",
                  {tx_k_o, tx_data_o}, {e_tk, e_td});
            check("R6 R7 R8 lock", rx_lock_o, m_st == 2);
            check("R8 R9 valid", rx_valid_o, ev);
            if (ev) check("R5 R9 R10 payload", rx_payload_o, ep);
            check("R10 error flag", rx_err_o, e1);
            if (rx_valid_o && rt_en) begin
                bit found;
                found = 0;
                for (int i = 0; i < 4; i++) if (hist[i] == rx_payload_o) found = 1;
                n_chk++;
                if (!found) begin
                    n_fail++;
                    $display("FAIL R11 round trip actual=%h expected=%h", rx_payload_o, hist[(hp+3)%4]);
                end
            end
        end
        if (!rst) begin
            q.push_back({tx_k_o, tx_data_o});
            if (ins_req) begin
                cur = last_w; ins_req = 0;
            end else begin
                if (del_req && q.size() >= 2) begin void'(q.pop_front()); del_req = 0; end
                cur = (q.size() > 0) ? q.pop_front() : {2'b11, 16'h3C3C};
            end
            if (nosof_req && cur == {2'b11, 16'hBCBC}) begin cur = {2'b11, 16'h3C3C}; nosof_req = 0; end
            else if (err1_req && cur[17:16] == 2'b00) begin cur = {2'b01, cur[15:0]}; err1_req = 0; end
            else if (err2_req && cur[17:16] == 2'b00) begin cur = {2'b11, 16'hF7F7}; err2_req = 0; end
            else if (stray_req && cur[17:16] == 2'b00) begin cur = {2'b11, 16'hBCBC}; stray_req = 0; end
            last_w = cur;
            rx_k_i = cur[17:16]; rx_data_i = cur[15:0];
            if (tx_take_o) begin
                tx_payload_i = gen_payload(special);
                hist[hp] = tx_payload_i; hp = (hp + 1) % 4;
            end
        end
    end

    task automatic frames(input int n);
        repeat (n * FW) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) hist[i] = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset tx word", {tx_k_o, tx_data_o}, {2'b11, 16'h3C3C});
        check("R4 reset take", tx_take_o, 1'b0);
        check("R4 reset lock", rx_lock_o, 1'b0);
        check("R4 reset valid", rx_valid_o, 1'b0);
        check("R4 reset err", rx_err_o, 1'b0);
        @(negedge clk) rst = 1'b0;

        // clean loopback with zero-rich payloads
        rt_en = 1; frames(60); #1;
        check("R6 locked after clean run", rx_lock_o, 1'b1);
        rt_en = 0;

        // slips: delete, then insert
        @(posedge clk) del_req = 1; frames(30); #1;
        check("R8 relock after deletion", rx_lock_o, 1'b1);
        @(posedge clk) ins_req = 1; frames(30); #1;
        check("R8 relock after insertion", rx_lock_o, 1'b1);

        // single missing frame start keeps lock
        @(posedge clk) nosof_req = 1; wait (!nosof_req); repeat (20) @(posedge clk); #1;
        check("R7 lock held after one miss", rx_lock_o, 1'b1);
        frames(6);

        // two consecutive misses drop lock, then a stray comma while acquiring
        @(posedge clk) nosof_req = 1; wait (!nosof_req);
        @(posedge clk) nosof_req = 1; wait (!nosof_req);
        repeat (6) @(posedge clk); #1;
        check("R7 lock lost after two misses", rx_lock_o, 1'b0);
        frames(2); @(posedge clk) stray_req = 1; frames(12);

        // coding errors and stray commas while locked
        @(posedge clk) err1_req = 1; frames(3);
        @(posedge clk) err2_req = 1; frames(3);
        @(posedge clk) stray_req = 1; frames(10);

        // data words shaped like comma codes
        special = 1; frames(20);
        rt_en = 1; frames(40);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..R11 run not finished actual=timeout expected=end");
        finish_run();
    end

endmodule